// File: doc/BRIEF.md
# Expanded Data RAM and External Bus Router

This block takes the data-memory move requests of an 8-bit microcontroller core and decides, access by access, where each one is served. There are two targets. One is an on-chip expanded data RAM of 768 bytes, reached in a single access cycle with no bus activity. The other is an off-chip memory on a multiplexed bus, made up of:
- a low port that carries the address low byte and then the data;
- a high port that carries the address high byte;
- an address latch enable;
- separate active-low read and write strobes.

An auxiliary control register holds two bits:
- a route-external bit, which sends every access off chip;
- a latch-quiet bit, which stops the free-running address latch enable so that it pulses only during bus cycles.

With route-external clear, a wide (16-bit pointer) access below the RAM size stays on chip, and a wide access at or above that size goes off chip. A narrow (8-bit register-pointer) access always stays on chip.

The FSM has seven states:

| State | Role |
|-------|------|
| IDLE | Waits for a request |
| INT | One-cycle RAM access |
| EADDR | Drives the address on both ports |
| EALE | Latch enable high |
| EDATA | Data setup phase |
| ESTRB | Strobe low for a fixed count |
| FIN | One-cycle completion |

The transitions are:
- IDLE→INT when a request routes internal.
- IDLE→EADDR when a request routes external.
- INT→FIN.
- EADDR→EALE.
- EALE→EDATA.
- EDATA→ESTRB.
- ESTRB→ESTRB until the strobe count is reached, then ESTRB→FIN.
- FIN→IDLE.

Top module: `xram_bus_router`

## Requirements
- R1: While reset is asserted, the outputs are idle: `done`=0, `p0_oe`=0, `p0_out`=0xFF, `p2_out`=0xFF, `wr_n`=1, `rd_n`=1, `ale`=0. The control register clears to zero.
- R2: A control write takes effect only when `sfr_addr` is 0x8E. Data bit 1 is route-external and bit 0 is latch-quiet; bits 7..2 are ignored. A write to any other address changes nothing.
- R3: With route-external clear, a wide access (`req_wide`=1) below 0x0300 is served by the on-chip RAM at `req_addr[9:0]`. No strobe goes low, and `done` pulses in the second cycle after acceptance.
- R4: With route-external clear, a wide access at 0x0300 or above runs an external bus cycle.
- R5: With route-external clear, a narrow access (`req_wide`=0) uses only `req_addr[7:0]` as the on-chip RAM location, with no strobes.
- R6: With route-external set, every access, wide or narrow, runs an external bus cycle and leaves the on-chip RAM untouched.
- R7: An external cycle, counting k cycles after acceptance with S = STROBE_CYCLES, runs as follows:
  - k=1: the address is driven.
  - k=2: `ale` is high.
  - k=3: data setup.
  - k=4..3+S: the strobe is low.
  - k=4+S: `done`.
  - Through k=1..3+S, `p2_out` carries `req_addr[15:8]` for a wide access and 0xFF for a narrow one.
  - Through k=1..2, `p0_out` carries `req_addr[7:0]` with `p0_oe`=1.
- R8: An external write drives the write data on `p0_out` with `p0_oe`=1 through k=3..3+S and pulses `wr_n` low. An external read releases `p0_oe`, pulses `rd_n` low and captures `p0_in` on the last strobe cycle. The two strobes are never low together.
- R9: With latch-quiet clear, `ale` is high for one cycle in every ALE_DIV cycles. This is the cycle in which the count of clocks since reset modulo ALE_DIV equals ALE_DIV-1. These pulses are suppressed during k=1..3+S of an external cycle.
- R10: With latch-quiet set, `ale` is high only in the latch phase of an external cycle.
- R11: `done` is a one-cycle pulse, and for a read `rdata` holds the result from either target while `done` is high.
- R12: A request is accepted only in IDLE. A request held high during an access is taken again only after the FIN cycle, so a held internal read completes once every three cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sfr_we | input | 1 | Special register write strobe |
| sfr_addr | input | 8 | Special register address |
| sfr_wdata | input | 8 | Special register write data |
| req_valid | input | 1 | Access request |
| req_wide | input | 1 | 1: 16-bit pointer access, 0: 8-bit register pointer |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | Access complete pulse |
| rdata | output | 8 | Read result |
| p0_out | output | 8 | Low address / data port output |
| p0_oe | output | 1 | Low port drive enable |
| p0_in | input | 8 | Low port input data |
| p2_out | output | 8 | High address port |
| ale | output | 1 | Address latch enable |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |

## Verification
The hardest situations to reach are a request held high across the FIN cycle, and the free-running latch pulse meeting an external cycle that must suppress it. Neither shows up if requests are issued one by one after `done`. The stimulus therefore holds `req_valid` high for a fixed window of back-to-back internal reads. It also starts external accesses at varying phases of the latch divider by inserting idle gaps and control writes of different lengths. A behavioural model tracks the divider phase and the access phase, and the outputs are compared against it on every clock.

// File: rtl/xram_pkg.sv
package xram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INT,
        ST_EADDR,
        ST_EALE,
        ST_EDATA,
        ST_ESTRB,
        ST_FIN
    } route_state_e;

    localparam logic [7:0] PORT_IDLE = 8'hFF;

endpackage

// File: rtl/xram_aux_reg.sv
module xram_aux_reg #(
    parameter logic [7:0] REG_ADDR = 8'h8E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [1:0] wr_bits,
    output logic       route_ext,
    output logic       ale_quiet
);

    logic hit;
    assign hit = wr_en && (wr_addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_ext <= 1'b0;
            ale_quiet <= 1'b0;
        end else if (hit) begin
            route_ext <= wr_bits[1];
            ale_quiet <= wr_bits[0];
        end
    end

    // R2: a decoded write loads both control bits on the next edge
    a_r2_aux_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_ADDR) |=>
            (route_ext == $past(wr_bits[1]) && ale_quiet == $past(wr_bits[0])));

    // R2: writes to other addresses leave the register alone
    a_r2_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != REG_ADDR) |=> ($stable(route_ext) && $stable(ale_quiet)));

endmodule

// File: rtl/xram_ale_tick.sv
module xram_ale_tick #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == CW'(DIV - 1));

    // R9: the divider pulse never lasts two cycles
    a_r9_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/xram_store.sv
module xram_store #(
    parameter int BYTES = 768,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/xram_bus_router.sv
module xram_bus_router
    import xram_pkg::*;
#(
    parameter int         XRAM_BYTES    = 768,
    parameter int         STROBE_CYCLES = 3,
    parameter int         ALE_DIV       = 6,
    parameter logic [7:0] AUX_SFR_ADDR  = 8'h8E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sfr_we,
    input  logic [7:0]  sfr_addr,
    input  logic [7:0]  sfr_wdata,
    input  logic        req_valid,
    input  logic        req_wide,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    output logic        done,
    output logic [7:0]  rdata,
    output logic [7:0]  p0_out,
    output logic        p0_oe,
    input  logic [7:0]  p0_in,
    output logic [7:0]  p2_out,
    output logic        ale,
    output logic        wr_n,
    output logic        rd_n
);

    localparam int          RAM_AW     = $clog2(XRAM_BYTES);
    localparam int          CNT_W      = $clog2(STROBE_CYCLES + 1);
    localparam logic [15:0] XRAM_LIMIT = 16'(XRAM_BYTES);

    route_state_e state_q, state_d;

    logic             route_ext, ale_quiet, div_tick;
    logic             wide_q, write_q;
    logic [15:0]      addr_q;
    logic [7:0]       wdata_q, rdata_q;
    logic [CNT_W-1:0] strb_cnt_q;
    logic             go_ext, strb_last;
    logic             ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [7:0]       ram_rdata;
    logic             ext_busy, ale_phase;

    xram_aux_reg #(.REG_ADDR(AUX_SFR_ADDR)) aux_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sfr_we),
        .wr_addr   (sfr_addr),
        .wr_bits   (sfr_wdata[1:0]),
        .route_ext (route_ext),
        .ale_quiet (ale_quiet)
    );

    xram_ale_tick #(.DIV(ALE_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (div_tick)
    );

    xram_store #(.BYTES(XRAM_BYTES), .AW(RAM_AW)) store_i (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (wdata_q),
        .rdata (ram_rdata)
    );

    // Routing decision for the request presented in IDLE
    assign go_ext    = route_ext || (req_wide && (req_addr >= XRAM_LIMIT));
    assign strb_last = (strb_cnt_q == CNT_W'(STROBE_CYCLES - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = go_ext ? ST_EADDR : ST_INT;
            ST_INT:   state_d = ST_FIN;
            ST_EADDR: state_d = ST_EALE;
            ST_EALE:  state_d = ST_EDATA;
            ST_EDATA: state_d = ST_ESTRB;
            ST_ESTRB: if (strb_last) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Access capture, strobe counter and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q     <= 1'b0;
            write_q    <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
            strb_cnt_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                wide_q  <= req_wide;
                write_q <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_EDATA)
                strb_cnt_q <= '0;
            else if (state_q == ST_ESTRB)
                strb_cnt_q <= strb_cnt_q + 1'b1;
            if (state_q == ST_INT)
                rdata_q <= ram_rdata;
            else if (state_q == ST_ESTRB && strb_last && !write_q)
                rdata_q <= p0_in;
        end
    end

    assign ram_we   = (state_q == ST_INT) && write_q;
    assign ram_addr = wide_q ? addr_q[RAM_AW-1:0] : RAM_AW'(addr_q[7:0]);

    // Output logic
    always_comb begin
        done      = 1'b0;
        p0_out    = PORT_IDLE;
        p0_oe     = 1'b0;
        p2_out    = PORT_IDLE;
        wr_n      = 1'b1;
        rd_n      = 1'b1;
        ext_busy  = 1'b0;
        ale_phase = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_INT: ;
            ST_EADDR, ST_EALE: begin
                ext_busy  = 1'b1;
                ale_phase = (state_q == ST_EALE);
                p0_out    = addr_q[7:0];
                p0_oe     = 1'b1;
                p2_out    = wide_q ? addr_q[15:8] : PORT_IDLE;
            end
            ST_EDATA, ST_ESTRB: begin
                ext_busy = 1'b1;
                p2_out   = wide_q ? addr_q[15:8] : PORT_IDLE;
                if (write_q) begin
                    p0_out = wdata_q;
                    p0_oe  = 1'b1;
                end
                if (state_q == ST_ESTRB) begin
                    wr_n = !write_q;
                    rd_n = write_q;
                end
            end
            ST_FIN:  done = 1'b1;
            default: ;
        endcase
    end

    assign ale   = ale_phase || (!ale_quiet && div_tick && !ext_busy);
    assign rdata = rdata_q;

    // R3: an internal wide access below the limit never strobes
    a_r3_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && !route_ext && req_wide && req_addr < XRAM_LIMIT)
            |=> (wr_n && rd_n) ##1 (done && wr_n && rd_n));

    // R5: a narrow access with route-external clear never strobes
    a_r5_narrow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && !route_ext && !req_wide)
            |=> (wr_n && rd_n) ##1 done);

    // R8: the strobes are exclusive and a read releases the low port
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));
    a_r8_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !p0_oe);

    // R10: with latch-quiet set, no latch pulse outside a bus cycle
    a_r10_ale_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_quiet && state_q == ST_IDLE) |-> !ale);

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/xram_bus_router_tb_top.sv
`timescale 1ns/1ps
module xram_bus_router_tb_top;

    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic        req_valid = 1'b0;
    logic        req_wide = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = 16'h0000;
    logic [7:0]  req_wdata = 8'h00;
    logic        done, p0_oe, ale, wr_n, rd_n;
    logic [7:0]  rdata, p0_out, p0_in, p2_out;

    always #5 clk = ~clk;

    xram_bus_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .req_valid(req_valid), .req_wide(req_wide), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata),
        .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out),
        .ale(ale), .wr_n(wr_n), .rd_n(rd_n)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ext_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    // Behavioural reference model
    bit          m_active = 0, m_ext = 0, m_wr = 0, m_wide = 0, m_sel = 0, m_off = 0;
    int          m_k = 0, m_ncyc = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wdata = '0, m_exp_rd = '0;
    logic [7:0]  mmem [768];

    assign p0_in = ext_val(m_wide ? m_addr : {8'h00, m_addr[7:0]});

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_k = 0; m_sel = 0; m_off = 0; m_ncyc = 0;
        end else begin
            m_ncyc++;
            if (m_active) begin
                m_k++;
                if (m_k > (m_ext ? 4 + S : 2)) m_active = 0;
            end else if (req_valid) begin
                int idx;
                m_active = 1; m_k = 1;
                m_wide = req_wide; m_wr = req_write;
                m_addr = req_addr; m_wdata = req_wdata;
                m_ext = m_sel || (req_wide && req_addr >= 16'h0300);
                if (!m_ext) begin
                    idx = req_wide ? int'(req_addr[9:0]) : int'(req_addr[7:0]);
                    m_exp_rd = mmem[idx];
                    if (req_write) mmem[idx] = req_wdata;
                end else begin
                    m_exp_rd = ext_val(req_wide ? req_addr : {8'h00, req_addr[7:0]});
                end
            end
            if (sfr_we && sfr_addr == 8'h8E) begin
                m_sel = sfr_wdata[1];
                m_off = sfr_wdata[0];
            end
        end
    end

    // Per-cycle comparison plus monitors
    bit         strobe_seen = 0;
    int         done_cnt = 0;
    logic [7:0] last_rd = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_done, e_oe, e_ale, e_wr, e_rd;
            logic [7:0] e_p0, e_p2;
            e_done = 0; e_oe = 0; e_wr = 1; e_rd = 1; e_p0 = 8'hFF; e_p2 = 8'hFF;
            e_ale = !m_off && (m_ncyc % 6 == 5);
            if (m_active && m_ext) begin
                if (m_k <= 3 + S) begin
                    e_ale = (m_k == 2);
                    e_p2  = m_wide ? m_addr[15:8] : 8'hFF;
                    if (m_k <= 2) begin e_oe = 1; e_p0 = m_addr[7:0]; end
                    else if (m_wr) begin e_oe = 1; e_p0 = m_wdata; end
                    if (m_k >= 4) begin e_wr = !m_wr; e_rd = m_wr; end
                end
                if (m_k == 4 + S) e_done = 1;
            end else if (m_active && m_k == 2) begin
                e_done = 1;
            end
            chk(ale == e_ale, m_off ? "R10" : "R9", "ale", ale, e_ale);
            chk(wr_n == e_wr && rd_n == e_rd, "R8", "strobes", {wr_n, rd_n}, {e_wr, e_rd});
            chk(p0_oe == e_oe, "R7", "p0_oe", p0_oe, e_oe);
            if (e_oe) chk(p0_out == e_p0, "R7", "p0_out", p0_out, e_p0);
            chk(p2_out == e_p2, "R7", "p2_out", p2_out, e_p2);
            chk(done == e_done, "R11", "done", done, e_done);
            if (e_done && !m_wr) chk(rdata == m_exp_rd, "R11", "rdata", rdata, m_exp_rd);
            if (!wr_n || !rd_n) strobe_seen = 1;
            if (done) begin done_cnt++; last_rd = rdata; end
        end
    end

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); sfr_we = 1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk); sfr_we = 0;
    endtask

    task automatic access(input bit wide, input bit wr, input logic [15:0] a,
                          input logic [7:0] d);
        @(negedge clk);
        strobe_seen = 0;
        req_valid = 1; req_wide = wide; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        while (m_active) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle outputs under reset
        chk(done == 0 && p0_oe == 0 && wr_n && rd_n && ale == 0, "R1", "ctl", {done, p0_oe, wr_n, rd_n, ale}, 5'b00110);
        chk(p0_out == 8'hFF && p2_out == 8'hFF, "R1", "ports", {p0_out, p2_out}, 16'hFFFF);
        rst_n = 1;
        repeat (14) @(negedge clk);

        // R2: wrong address ignored
        sfr_write(8'h8F, 8'h03);
        repeat (7) @(negedge clk);
        access(1, 1, 16'h0020, 8'h21);
        chk(!strobe_seen, "R2", "strobe after ignored write", strobe_seen, 0);
        sfr_write(8'h8E, 8'hFC);
        access(1, 1, 16'h02FF, 8'h5A);
        chk(!strobe_seen, "R2", "reserved bits only", strobe_seen, 0);
        access(1, 1, 16'h0000, 8'h11);
        chk(!strobe_seen, "R3", "internal write strobe", strobe_seen, 0);

        // R5: narrow uses low byte only
        access(0, 1, 16'hAB10, 8'h77);
        chk(!strobe_seen, "R5", "narrow write strobe", strobe_seen, 0);
        access(1, 0, 16'h0010, 8'h00);
        chk(last_rd == 8'h77, "R5", "narrow location", last_rd, 8'h77);
        access(1, 0, 16'h02FF, 8'h00);
        chk(last_rd == 8'h5A && !strobe_seen, "R3", "top of ram", last_rd, 8'h5A);
        access(0, 0, 16'h3400, 8'h00);
        chk(last_rd == 8'h11, "R5", "narrow read", last_rd, 8'h11);

        // R4: threshold and above go off chip
        access(1, 1, 16'h0300, 8'hE1);
        chk(strobe_seen, "R4", "0x300 write strobe", strobe_seen, 1);
        repeat (2) @(negedge clk);
        access(1, 0, 16'h1234, 8'h00);
        chk(strobe_seen && last_rd == ext_val(16'h1234), "R4", "ext read", last_rd, ext_val(16'h1234));
        access(1, 0, 16'hFFFF, 8'h00);

        // R6: route-external forces every access off chip
        sfr_write(8'h8E, 8'h02);
        access(0, 0, 16'h0055, 8'h00);
        chk(strobe_seen && last_rd == ext_val(16'h0055), "R6", "narrow ext", last_rd, ext_val(16'h0055));
        @(negedge clk);
        access(1, 1, 16'h0010, 8'h99);
        chk(strobe_seen, "R6", "low wide ext", strobe_seen, 1);

        // R10: latch-quiet with external cycles
        sfr_write(8'h8E, 8'h03);
        access(1, 0, 16'h0400, 8'h00);
        repeat (12) @(negedge clk);
        sfr_write(8'h8E, 8'h01);
        access(1, 0, 16'h0010, 8'h00);
        chk(last_rd == 8'h77 && !strobe_seen, "R6", "ram untouched by ext write", last_rd, 8'h77);
        repeat (8) @(negedge clk);

        // R12: held request re-accepted only after FIN
        sfr_write(8'h8E, 8'h00);
        @(negedge clk);
        done_cnt = 0;
        req_valid = 1; req_wide = 1; req_write = 0; req_addr = 16'h0010;
        repeat (12) @(negedge clk);
        req_valid = 0;
        chk(done_cnt == 4, "R12", "held request completions", done_cnt, 4);
        repeat (6) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule